// File: doc/BRIEF.md
# Pixel Expand and Pack Unit

This block converts pixel data between an 8-bit-per-component form and a 16-bit fixed-point form, so that lane-wise arithmetic can be done with headroom. An expand operation takes a 32-bit word holding four unsigned component bytes. It returns a 64-bit word holding four 16-bit fields, with each byte placed four bits above the bottom of its field.

A pack operation goes the other way. Each signed 16-bit field of a 64-bit word is shifted left by a programmable scale. One byte is then taken from a fixed window, and the result is saturated to 0..255. The four bytes are gathered into a 32-bit word.

The scale lives in a small status register that has its own write port. With a scale of 3, a pack exactly undoes an expand. If the fields of two expanded pixels are added before packing, the pack produces a per-component sum that saturates at 255.

Each operation is registered once. The result appears on the cycle after the request and holds until the next request.

Top module: `pxconv_unit`

## Requirements
- R1: While `rst` is high on a clock edge, `res_valid`, `res64`, `res32` and `scale` all become 0.
- R2: For an expand (`op_sel`=0), byte i of `src32` (bits 8i+7..8i) appears at `res64` bits 16i+11..16i+4, and bits 16i+3..16i and 16i+15..16i+12 are 0.
- R3: `res_valid` is 1 exactly on the cycle after a cycle with `op_valid`=1. `op_sel`=0 selects expand and `op_sel`=1 selects pack.
- R4: When `op_valid` is 0, `res64` and `res32` keep their values. An expand sets `res32` to 0, and a pack sets `res64` to 0.
- R5: A cycle with `stat_we`=1 loads `stat_wdata` bits 6..3 into the 4-bit scale, which is visible on `scale` the next cycle. Other bits of `stat_wdata` are ignored, and the scale is unchanged when `stat_we`=0.
- R6: A pack uses the scale held before its own cycle. A status write in the same cycle affects only later packs.
- R7: For a pack, field i of `src64` (bits 16i+15..16i) is read as signed, shifted left by the scale without loss, and bits 14..7 of the result go to `res32` bits 8i+7..8i when the shifted value is between 0 and 32767.
- R8: A pack field whose shifted value is negative gives byte 0.
- R9: A pack field whose shifted value is above 32767 gives byte 255.
- R10: With the scale at 3 (status write of 24), a pack of an expanded word returns the original word. Adding two expanded words lane-wise in 16 bits and packing 0x000102c8 with 0x000405c8 gives 0x000507ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_sel | input | 1 | 0 = expand, 1 = pack |
| src32 | input | 32 | Four component bytes for expand |
| src64 | input | 64 | Four signed 16-bit fields for pack |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 32 | Status register write data, scale at bits 6..3 |
| res_valid | output | 1 | Result registered this cycle |
| res64 | output | 64 | Expand result |
| res32 | output | 32 | Pack result |
| scale | output | 4 | Current scale field |

## Verification
The hardest case to reach is a status write and a pack issued in the same cycle, where the pack must still use the old scale. The bench drives both together on purpose, using a field whose packed byte differs between the old and new scales. It then issues a second pack to confirm that the new scale has taken effect.

Saturation at both ends also needs deliberate stimulus. Negative fields and fields pushed past bit 14 by large scales are driven at every scale from 0 to 15. Random traffic is also compared each cycle against a behavioural model.

// File: rtl/pxconv_pkg.sv
package pxconv_pkg;

    localparam int LANES_D   = 4;
    localparam int CMP_W_D   = 8;
    localparam int FLD_W_D   = 16;
    localparam int PAD_D     = 4;
    localparam int SCALE_W_D = 4;
    localparam int SCALE_LSB_D = 3;
    localparam int STAT_W_D  = 32;
    localparam int WIN_LSB_D = 7;

    typedef enum logic {
        OP_EXPAND = 1'b0,
        OP_PACK   = 1'b1
    } pxconv_op_e;

    typedef enum logic [1:0] {
        PK_WINDOW = 2'd0,
        PK_FLOOR  = 2'd1,
        PK_CEIL   = 2'd2
    } pack_case_e;

    function automatic pack_case_e classify(input logic neg, input logic over);
        if (neg)       return PK_FLOOR;
        else if (over) return PK_CEIL;
        else           return PK_WINDOW;
    endfunction

endpackage

// File: rtl/pxconv_scale_reg.sv
module pxconv_scale_reg #(
    parameter int STAT_W    = 32,
    parameter int SCALE_W   = 4,
    parameter int SCALE_LSB = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [STAT_W-1:0]  wdata,
    output logic [SCALE_W-1:0] scale_q
);
    localparam int SCALE_MSB = SCALE_LSB + SCALE_W - 1;

    always_ff @(posedge clk) begin
        if (rst)
            scale_q <= '0;
        else if (we)
            scale_q <= wdata[SCALE_MSB:SCALE_LSB];
    end
endmodule

// File: rtl/pxconv_expand.sv
module pxconv_expand #(
    parameter int LANES = 4,
    parameter int CMP_W = 8,
    parameter int FLD_W = 16,
    parameter int PAD   = 4
) (
    input  logic [LANES*CMP_W-1:0] bytes_in,
    output logic [LANES*FLD_W-1:0] fields_out
);
    localparam int HI_PAD = FLD_W - CMP_W - PAD;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fields_out[g*FLD_W +: FLD_W] =
            {{HI_PAD{1'b0}}, bytes_in[g*CMP_W +: CMP_W], {PAD{1'b0}}};
    end
endmodule

// File: rtl/pxconv_pack_lane.sv
module pxconv_pack_lane
    import pxconv_pkg::*;
#(
    parameter int FLD_W   = 16,
    parameter int CMP_W   = 8,
    parameter int SCALE_W = 4,
    parameter int WIN_LSB = 7
) (
    input  logic [FLD_W-1:0]   field,
    input  logic [SCALE_W-1:0] scale,
    output logic [CMP_W-1:0]   byte_out
);
    localparam int EXT_W   = FLD_W + (2**SCALE_W) - 1;
    localparam int WIN_TOP = WIN_LSB + CMP_W - 1;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] shf;
    logic             neg;
    logic             over;
    pack_case_e       sel;

    always_comb begin
        ext  = {{(EXT_W-FLD_W){field[FLD_W-1]}}, field};
        shf  = ext << scale;
        neg  = shf[EXT_W-1];
        over = |shf[EXT_W-2:WIN_TOP+1];
        sel  = classify(neg, over);
        unique case (sel)
            PK_FLOOR: byte_out = '0;
            PK_CEIL:  byte_out = '1;
            default:  byte_out = shf[WIN_TOP:WIN_LSB];
        endcase
    end
endmodule

// File: rtl/pxconv_unit.sv
module pxconv_unit
    import pxconv_pkg::*;
#(
    parameter int LANES     = LANES_D,
    parameter int CMP_W     = CMP_W_D,
    parameter int FLD_W     = FLD_W_D,
    parameter int PAD       = PAD_D,
    parameter int SCALE_W   = SCALE_W_D,
    parameter int SCALE_LSB = SCALE_LSB_D,
    parameter int STAT_W    = STAT_W_D,
    parameter int WIN_LSB   = WIN_LSB_D
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic                     op_sel,
    input  logic [LANES*CMP_W-1:0]   src32,
    input  logic [LANES*FLD_W-1:0]   src64,
    input  logic                     stat_we,
    input  logic [STAT_W-1:0]        stat_wdata,
    output logic                     res_valid,
    output logic [LANES*FLD_W-1:0]   res64,
    output logic [LANES*CMP_W-1:0]   res32,
    output logic [SCALE_W-1:0]       scale
);
    localparam int NARROW_W = LANES * CMP_W;
    localparam int WIDE_W   = LANES * FLD_W;

    pxconv_op_e          op;
    logic [WIDE_W-1:0]   exp_w;
    logic [NARROW_W-1:0] pack_w;

    assign op = pxconv_op_e'(op_sel);

    pxconv_scale_reg #(
        .STAT_W(STAT_W), .SCALE_W(SCALE_W), .SCALE_LSB(SCALE_LSB)
    ) u_scale (
        .clk(clk), .rst(rst), .we(stat_we), .wdata(stat_wdata), .scale_q(scale)
    );

    pxconv_expand #(
        .LANES(LANES), .CMP_W(CMP_W), .FLD_W(FLD_W), .PAD(PAD)
    ) u_expand (
        .bytes_in(src32), .fields_out(exp_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        pxconv_pack_lane #(
            .FLD_W(FLD_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W), .WIN_LSB(WIN_LSB)
        ) u_lane (
            .field(src64[g*FLD_W +: FLD_W]),
            .scale(scale),
            .byte_out(pack_w[g*CMP_W +: CMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res64     <= '0;
            res32     <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                if (op == OP_PACK) begin
                    res32 <= pack_w;
                    res64 <= '0;
                end else begin
                    res64 <= exp_w;
                    res32 <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/pxconv_unit_chk.sv
module pxconv_unit_chk #(
    parameter int LANES     = 4,
    parameter int CMP_W     = 8,
    parameter int FLD_W     = 16,
    parameter int PAD       = 4,
    parameter int SCALE_W   = 4,
    parameter int SCALE_LSB = 3,
    parameter int STAT_W    = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   op_valid,
    input logic                   op_sel,
    input logic [LANES*CMP_W-1:0] src32,
    input logic [LANES*FLD_W-1:0] src64,
    input logic                   stat_we,
    input logic [STAT_W-1:0]      stat_wdata,
    input logic                   res_valid,
    input logic [LANES*FLD_W-1:0] res64,
    input logic [LANES*CMP_W-1:0] res32,
    input logic [SCALE_W-1:0]     scale
);
    localparam int HI_PAD = FLD_W - CMP_W - PAD;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && res64 == '0 && res32 == '0 && scale == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R3

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid); // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(res64) && $stable(res32))); // R4

    AST_EXPAND_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_sel) |=> (res32 == '0)); // R4

    AST_PACK_WIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel) |=> (res64 == '0)); // R4

    AST_SCALE_LOAD: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> (scale == $past(stat_wdata[SCALE_LSB +: SCALE_W]))); // R5

    AST_SCALE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !stat_we |=> $stable(scale)); // R5

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        AST_EXPAND_PAD: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !op_sel) |=>
                (res64[g*FLD_W +: PAD] == '0 &&
                 res64[g*FLD_W + PAD + CMP_W +: HI_PAD] == '0)); // R2

        AST_EXPAND_BYTE: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !op_sel) |=>
                (res64[g*FLD_W + PAD +: CMP_W] == $past(src32[g*CMP_W +: CMP_W]))); // R2

        AST_PACK_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
            (op_valid && op_sel && src64[g*FLD_W + FLD_W - 1]) |=>
                (res32[g*CMP_W +: CMP_W] == '0)); // R8
    end
endmodule

bind pxconv_unit pxconv_unit_chk #(
    .LANES(LANES), .CMP_W(CMP_W), .FLD_W(FLD_W), .PAD(PAD),
    .SCALE_W(SCALE_W), .SCALE_LSB(SCALE_LSB), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .src32(src32), .src64(src64), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .res_valid(res_valid), .res64(res64), .res32(res32), .scale(scale)
);

// File: tb/pxconv_unit_test.sv
module pxconv_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic        op_sel;
    logic [31:0] src32;
    logic [63:0] src64;
    logic        stat_we;
    logic [31:0] stat_wdata;
    logic        res_valid;
    logic [63:0] res64;
    logic [31:0] res32;
    logic [3:0]  scale;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    started  = 0;
    bit    finished = 0;
    string cur_req  = "R1";

    bit        m_valid;
    bit [63:0] m_w;
    bit [31:0] m_n;
    int        m_scale;
    string     m_tag;

    always #4 clk = ~clk;

    pxconv_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .src32(src32), .src64(src64), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .res_valid(res_valid), .res64(res64), .res32(res32), .scale(scale)
    );

    function automatic int ref_byte(input int fld, input int sc);
        longint v;
        v = longint'(fld >= 32768 ? fld - 65536 : fld) * (longint'(1) << sc);
        if (v < 0) return 0;
        if (v > 32767) return 255;
        return int'((v / 128) % 256);
    endfunction

    function automatic bit [63:0] ref_expand(input bit [31:0] w);
        bit [63:0] r = '0;
        for (int i = 0; i < 4; i++)
            r[16*i +: 16] = 16'(int'(w[8*i +: 8]) * 16);
        return r;
    endfunction

    function automatic bit [31:0] ref_pack(input bit [63:0] w, input int sc);
        bit [31:0] r = '0;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = 8'(ref_byte(int'(w[16*i +: 16]), sc));
        return r;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_valid = 0; m_w = '0; m_n = '0; m_scale = 0;
        end else begin
            m_valid = op_valid;
            m_tag   = cur_req;
            if (op_valid) begin
                if (op_sel) begin
                    m_n = ref_pack(src64, m_scale); m_w = '0;
                end else begin
                    m_w = ref_expand(src32); m_n = '0;
                end
            end
            if (stat_we) m_scale = int'(stat_wdata[6:3]);
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check(m_tag, "res_valid", 64'(res_valid), 64'(m_valid));
            check(m_tag, "res64", res64, m_w);
            check(m_tag, "res32", 64'(res32), 64'(m_n));
            check(m_tag, "scale", 64'(scale), 64'(m_scale));
        end
    end

    task automatic apply(input bit ov, input bit os, input bit [31:0] a,
                         input bit [63:0] b, input bit we, input bit [31:0] wd);
        op_valid = ov; op_sel = os; src32 = a; src64 = b;
        stat_we = we; stat_wdata = wd;
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit [63:0] ea, eb, sum;
        rst = 1'b1;
        op_valid = 0; op_sel = 0; src32 = '0; src64 = '0;
        stat_we = 0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset res_valid", 64'(res_valid), 64'd0);
        check("R1", "reset res64", res64, 64'd0);
        check("R1", "reset res32", 64'(res32), 64'd0);
        check("R1", "reset scale", 64'(scale), 64'd0);
        rst = 1'b0;

        cur_req = "R5";
        apply(0, 0, '0, '0, 1, 32'hFFFF_FF98);
        check("R5", "scale from bits 6..3", 64'(scale), 64'd3);
        apply(0, 0, '0, '0, 0, 32'h0000_0078);
        check("R5", "scale kept without write", 64'(scale), 64'd3);

        cur_req = "R2";
        apply(1, 0, 32'h0001_02c8, '0, 0, '0);
        ea = res64;
        check("R2", "expand a", res64, 64'h0000_0010_0020_0c80);
        check("R3", "valid after expand", 64'(res_valid), 64'd1);
        apply(1, 0, 32'h0004_05c8, '0, 0, '0);
        eb = res64;
        check("R2", "expand b", res64, 64'h0000_0040_0050_0c80);
        for (int i = 0; i < 4; i++) sum[16*i +: 16] = ea[16*i +: 16] + eb[16*i +: 16];
        cur_req = "R10";
        apply(1, 1, '0, sum, 0, '0);
        check("R10", "clamped pixel sum", 64'(res32), 64'h0000_0000_0005_07ff);
        check("R4", "pack clears res64", res64, 64'd0);

        cur_req = "R4";
        apply(0, 0, 32'hFFFF_FFFF, 64'h1234_5678_9abc_def0, 0, '0);
        apply(0, 1, 32'hA5A5_A5A5, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0);
        check("R4", "held res32", 64'(res32), 64'h0005_07ff);
        check("R3", "valid low when idle", 64'(res_valid), 64'd0);

        cur_req = "R10";
        for (int k = 0; k < 20; k++) begin
            bit [31:0] w = $urandom;
            bit [63:0] e;
            apply(1, 0, w, '0, 0, '0);
            e = res64;
            apply(1, 1, '0, e, 0, '0);
            check("R10", "round trip", 64'(res32), 64'(w));
        end

        // R6: write and pack in the same cycle use the old scale (3)
        cur_req = "R6";
        apply(1, 1, '0, 64'h0000_0000_0000_0080, 1, 32'd5 << 3);
        check("R6", "same-cycle pack uses old scale", 64'(res32), 64'd8);
        apply(1, 1, '0, 64'h0000_0000_0000_0080, 0, '0);
        check("R6", "later pack uses new scale", 64'(res32), 64'd32);

        cur_req = "R8";
        for (int s = 0; s < 16; s++) begin
            apply(0, 0, '0, '0, 1, 32'(s) << 3);
            cur_req = "R8";
            apply(1, 1, '0, 64'h8000_ffff_c000_fff0, 0, '0);
            check("R8", "negative fields floor", 64'(res32), 64'd0);
            cur_req = "R9";
            apply(1, 1, '0, 64'h7fff_4000_0100_0001, 0, '0);
            check("R9", "ceil lane3", 64'(res32[31:24]), 64'(ref_byte(16'h7fff, s)));
            check("R7", "window lane0", 64'(res32[7:0]), 64'(ref_byte(1, s)));
        end
        apply(0, 0, '0, '0, 1, 32'd15 << 3);
        apply(1, 1, '0, 64'h0000_0000_0000_0001, 0, '0);
        check("R9", "bit 15 after shift saturates", 64'(res32), 64'd255);

        cur_req = "R7";
        for (int k = 0; k < 400; k++) begin
            bit we = ($urandom % 5) == 0;
            apply(bit'($urandom), bit'($urandom), $urandom,
                  {$urandom, $urandom}, we, $urandom);
        end
        apply(0, 0, '0, '0, 0, '0);
        summary();
    end
endmodule